// File: doc/BRIEF.md
# Three-Channel PWM Program Loader

This block sits behind a byte-wide host register port and prepares three independent pulse-width channels for their engines. The host performs byte writes and combinational byte reads at an 8-bit address. A single control register carries one run-enable bit per channel. The host reads it back so that it can change one channel's bit without disturbing the others.

Each channel has one instruction port, a single byte address. A 16-bit instruction reaches that port as two successive byte writes, most significant byte first. When the second byte arrives, the complete word is stored at the channel's write pointer in a 64-word program store, and the pointer advances. Clearing a channel's run enable rewinds its loader, so the host can stop a channel and load a fresh program.

The enable bits, the stored words and the number of words loaded per channel are presented to the channel engines. Each engine reads its program store through its own read address.

Top module: `pwm_prog_loader`

## Requirements
- R1: After reset, all enable bits are 0, the control register reads 0x00, and every channel's loaded-word count is 0.
- R2: A write to address 0x30 loads wdata bits 2:0 into the enable register, where bit n enables channel n. A read of 0x30 returns the enable bits in bits 2:0, and bits 7:3 read as zero.
- R3: A control write replaces the enable bits with the written value. A read-modify-write that changes one bit leaves the other two enable outputs unchanged.
- R4: Addresses 0x38, 0x39 and 0x3A are the instruction ports of channels 0, 1 and 2. Writes to any other address, including 0x3B and 0x37, change no program store and no count.
- R5: The first byte written to a port is the high byte and the second is the low byte. The second byte stores {high, low} at the channel's current count, which is the entry index, and then increments the count by one.
- R6: A channel stores at most 64 words. Once the count is 64, further pairs are discarded and entries 0 to 63 keep their contents.
- R7: A control write that changes a channel's enable bit from 1 to 0 resets that channel's count to 0 and its byte phase to "high byte next". Channels whose bit was already 0 are unaffected.
- R8: Reads of the instruction ports and of any undecoded address return 0x00.
- R9: A lone high byte changes neither the count nor the store until its low byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| addr | input | 8 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (combinational from addr) |
| chan_en | output | 3 | Run enable per channel |
| prog_len | output | 21 | Loaded-word count per channel, 7 bits each, channel 0 lowest |
| eng_raddr | input | 18 | Engine read address per channel, 6 bits each |
| eng_rdata | output | 48 | Engine read word per channel, 16 bits each |

## Verification
Loading is exercised with short runs of distinct words on one channel, a full 66-pair run that overflows channel 0, and a split pair whose high byte stands alone before its low byte. Together these separate correct byte order, pointer advance, saturation at 64 as opposed to wrap-around, and premature commits. Enable patterns 0b101 to 0b111 to 0b110 show that individual bits are preserved. A stale high byte left on a channel before its enable is cleared shows whether the phase flag is rewound along with the pointer. Writes to neighbouring addresses 0x37 and 0x3B, together with reads of the ports, show that the decode is exact.

// File: rtl/pwm_ld_pkg.sv
package pwm_ld_pkg;
    localparam int unsigned NUM_CH     = 3;
    localparam int unsigned PROG_DEPTH = 64;
    localparam logic [7:0]  CTRL_ADDR  = 8'h30;
    localparam logic [7:0]  PORT_BASE  = 8'h38;
endpackage

// File: rtl/pwm_ld_decode.sv
module pwm_ld_decode #(
    parameter int unsigned NCH       = 3,
    parameter logic [7:0]  CTRL_ADDR = 8'h30,
    parameter logic [7:0]  PORT_BASE = 8'h38
) (
    input  logic           wr_en,
    input  logic [7:0]     addr,
    input  logic [NCH-1:0] en_q,
    output logic           ctrl_wr,
    output logic [NCH-1:0] port_wr,
    output logic [7:0]     rdata
);
    assign ctrl_wr = wr_en && (addr == CTRL_ADDR);

    for (genvar g = 0; g < NCH; g++) begin : g_port
        localparam logic [7:0] PADDR = PORT_BASE + 8'(g);
        assign port_wr[g] = wr_en && (addr == PADDR);
    end

    // Only the control register returns data; ports and holes read zero
    always_comb begin
        rdata = 8'h00;
        if (addr == CTRL_ADDR) begin
            rdata = {{(8-NCH){1'b0}}, en_q};
        end
    end

    always_comb begin
        a_r4_port_onehot: assert ($onehot0(port_wr));
        a_r4_ctrl_port_excl: assert (!(ctrl_wr && (port_wr != '0)));
    end
endmodule

// File: rtl/pwm_ld_channel.sv
module pwm_ld_channel #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          clr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    output logic [LW-1:0] len
);
    typedef struct packed {
        logic          phase;   // 1: high byte held, low byte next
        logic [7:0]    hi;
        logic [LW-1:0] len;
    } ld_state_t;

    ld_state_t st_d, st_q;
    logic      commit;
    logic [15:0] mem_q [DEPTH];

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (clr) begin
            st_d.phase = 1'b0;
            st_d.len   = '0;
        end else if (wr) begin
            if (!st_q.phase) begin
                st_d.hi    = wdata;
                st_d.phase = 1'b1;
            end else begin
                st_d.phase = 1'b0;
                if (st_q.len < LW'(DEPTH)) begin
                    commit   = 1'b1;
                    st_d.len = st_q.len + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            mem_q[st_q.len[AW-1:0]] <= {st_q.hi, wdata};
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign len     = st_q.len;

    a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len <= LW'(DEPTH));
    a_r5_len_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && st_q.phase && st_q.len < LW'(DEPTH)) |=> (st_q.len == $past(st_q.len) + 1'b1));
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && st_q.len == LW'(DEPTH)) |=> (st_q.len == LW'(DEPTH)));
    a_r7_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.len == '0 && !st_q.phase));
    a_r9_hi_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && !st_q.phase) |=> ($stable(st_q.len) && st_q.phase));
endmodule

// File: rtl/pwm_prog_loader.sv
module pwm_prog_loader #(
    parameter int unsigned NCH       = pwm_ld_pkg::NUM_CH,
    parameter int unsigned DEPTH     = pwm_ld_pkg::PROG_DEPTH,
    parameter logic [7:0]  CTRL_ADDR = pwm_ld_pkg::CTRL_ADDR,
    parameter logic [7:0]  PORT_BASE = pwm_ld_pkg::PORT_BASE,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned LW       = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [NCH-1:0]    chan_en,
    output logic [NCH*LW-1:0] prog_len,
    input  logic [NCH*AW-1:0] eng_raddr,
    output logic [NCH*16-1:0] eng_rdata
);
    typedef struct packed {
        logic [NCH-1:0] en;
    } top_state_t;

    top_state_t     st_d, st_q;
    logic           ctrl_wr;
    logic [NCH-1:0] port_wr;
    logic [NCH-1:0] clr;

    pwm_ld_decode #(
        .NCH(NCH), .CTRL_ADDR(CTRL_ADDR), .PORT_BASE(PORT_BASE)
    ) u_dec (
        .wr_en(wr_en), .addr(addr), .en_q(st_q.en),
        .ctrl_wr(ctrl_wr), .port_wr(port_wr), .rdata(rdata)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (ctrl_wr) begin
            st_d.en = wdata[NCH-1:0];
            clr     = st_q.en & ~wdata[NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_en = st_q.en;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_ld_channel #(.DEPTH(DEPTH)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr(port_wr[g]), .clr(clr[g]), .wdata(wdata),
            .rd_addr(eng_raddr[g*AW +: AW]),
            .rd_data(eng_rdata[g*16 +: 16]),
            .len(prog_len[g*LW +: LW])
        );
    end

    a_r3_hold_en: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(chan_en));
    a_r2_load_en: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (chan_en == $past(wdata[NCH-1:0])));
    always_comb begin
        a_r2_upper_zero: assert (addr != CTRL_ADDR || rdata[7:NCH] == '0);
        a_r8_port_reads_zero: assert (addr == CTRL_ADDR || rdata == 8'h00);
    end
endmodule

// File: tb/pwm_prog_loader_tb.sv
module pwm_prog_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [2:0]  chan_en;
    logic [20:0] prog_len;
    logic [17:0] eng_raddr = '0;
    logic [47:0] eng_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_prog_loader u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .chan_en(chan_en), .prog_len(prog_len),
        .eng_raddr(eng_raddr), .eng_rdata(eng_rdata)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00;
    endtask

    task automatic load(int ch, logic [15:0] w);
        wr(8'h38 + 8'(ch), w[15:8]);
        wr(8'h38 + 8'(ch), w[7:0]);
    endtask

    function automatic logic [6:0] len_of(int ch);
        return prog_len[ch*7 +: 7];
    endfunction

    task automatic word_of(int ch, int idx, output logic [15:0] w);
        @(negedge clk);
        eng_raddr[ch*6 +: 6] = 6'(idx);
        #1;
        w = eng_rdata[ch*16 +: 16];
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(8'h30, d);
        chk("R1 ctrl read", d, 8'h00);
        chk("R1 chan_en", chan_en, 3'b000);
        chk("R1 lengths", prog_len, 21'h0);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        wr(8'h30, 8'hFF);
        rd(8'h30, d);
        chk("R2 upper bits zero", d, 8'h07);
        chk("R2 chan_en all", chan_en, 3'b111);
        wr(8'h30, 8'h05);
        rd(8'h30, d);
        chk("R2 readback 101", d, 8'h05);
    endtask

    task automatic t_rmw();
        logic [7:0] d;
        rd(8'h30, d);
        wr(8'h30, d | 8'h02);
        chk("R3 set bit1 keeps others", chan_en, 3'b111);
        rd(8'h30, d);
        wr(8'h30, d & ~8'h01);
        chk("R3 clear bit0 keeps others", chan_en, 3'b110);
        wr(8'h30, 8'h00);
        chk("R3 all off", chan_en, 3'b000);
    endtask

    task automatic t_load();
        logic [15:0] w;
        load(1, 16'hA1B2);
        load(1, 16'h0C3D);
        load(1, 16'hFF00);
        chk("R5 ch1 len", len_of(1), 7'd3);
        chk("R4 ch0 untouched", len_of(0), 7'd0);
        chk("R4 ch2 untouched", len_of(2), 7'd0);
        word_of(1, 0, w); chk("R5 ch1 w0 byte order", w, 16'hA1B2);
        word_of(1, 1, w); chk("R5 ch1 w1", w, 16'h0C3D);
        word_of(1, 2, w); chk("R5 ch1 w2", w, 16'hFF00);
    endtask

    task automatic t_addr();
        logic [7:0] d;
        wr(8'h3B, 8'h12); wr(8'h3B, 8'h34);
        wr(8'h37, 8'h56); wr(8'h37, 8'h78);
        chk("R4 holes ignored ch0", len_of(0), 7'd0);
        chk("R4 holes ignored ch1", len_of(1), 7'd3);
        chk("R4 holes ignored ch2", len_of(2), 7'd0);
        chk("R4 hole no ctrl", chan_en, 3'b000);
        rd(8'h39, d); chk("R8 port read", d, 8'h00);
        rd(8'h3B, d); chk("R8 hole read", d, 8'h00);
        rd(8'h00, d); chk("R8 addr0 read", d, 8'h00);
    endtask

    task automatic t_half();
        logic [15:0] w;
        wr(8'h3A, 8'h9E);
        chk("R9 lone high byte", len_of(2), 7'd0);
        wr(8'h3A, 8'h71);
        chk("R9 pair done", len_of(2), 7'd1);
        word_of(2, 0, w); chk("R9 split word", w, 16'h9E71);
    endtask

    task automatic t_full();
        logic [15:0] w;
        for (int i = 0; i < 66; i++) begin
            load(0, 16'(i * 16'h0101) ^ 16'h5A00);
        end
        chk("R6 len saturates", len_of(0), 7'd64);
        word_of(0, 0, w);  chk("R6 entry0 kept", w, 16'h5A00);
        word_of(0, 63, w); chk("R6 entry63", w, 16'(63 * 16'h0101) ^ 16'h5A00);
    endtask

    task automatic t_clear();
        logic [15:0] w;
        wr(8'h3A, 8'hEE);
        wr(8'h30, 8'h05);
        chk("R7 len kept while enabled", len_of(0), 7'd64);
        wr(8'h30, 8'h00);
        chk("R7 ch0 rewound", len_of(0), 7'd0);
        chk("R7 ch2 rewound", len_of(2), 7'd0);
        chk("R7 ch1 unaffected", len_of(1), 7'd3);
        load(0, 16'h1357);
        chk("R7 ch0 reload len", len_of(0), 7'd1);
        word_of(0, 0, w); chk("R7 ch0 reload entry0", w, 16'h1357);
        load(2, 16'h2468);
        word_of(2, 0, w); chk("R7 phase rewound", w, 16'h2468);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_rmw();
        t_load();
        t_addr();
        t_half();
        t_full();
        t_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule